// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two 8-bit buses, called A and B, and can pass data between them either live or from storage. It holds two capture registers. The forward register stores the A-bus value and feeds the B side. The reverse register stores the B-bus value and feeds the A side. Each register has its own capture clock. An active-low output enable and a direction input decide which bus, if either, the block drives. For each direction, a select input chooses between the live value from the opposite bus and the stored register contents.

Every bus pin is split into an input, a data output and an output-enable vector, so the block can be synthesized and the pads stay outside it. The two capture clocks are treated as slow control signals. A common system clock samples them, and a capture takes place on the first system clock edge at which a capture clock reads high after having read low. Capturing continues while both buses are released, so the block can store A-side data and B-side data independently during isolation.

Top module: `dual_reg_bus_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both capture registers to all zeros. A stored path selected after reset therefore outputs 0x00.
- R2: A rising edge on the forward capture clock stores the A-bus input into the forward register. The stored value appears on the B-side data output when the forward select is high (1 = stored, 0 = live).
- R3: A rising edge on the reverse capture clock stores the B-bus input into the reverse register. The stored value appears on the A-side data output when the reverse select is high.
- R4: With a select low, the data output on that side equals the opposite bus input in the same cycle, with no register on the path.
- R5: With the output enable high (inactive), both output-enable vectors are all zeros (isolation).
- R6: With the output enable low, direction 1 sets the B-side enable vector to all ones and the A-side vector to all zeros. Direction 0 does the reverse. Each vector is always all ones or all zeros.
- R7: Captures on either clock still work while the output enable is high.
- R8: The two output-enable vectors are never both non-zero.
- R9: Only a low-to-high change of a capture clock stores data. Holding the clock high or taking it low leaves the register unchanged.
- R10: A capture on one clock leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the capture clocks and updates the registers |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Value currently present on the A bus |
| b_in | input | 8 | Value currently present on the B bus |
| cap_clk_fwd | input | 1 | Forward capture clock; its rising edge stores a_in |
| cap_clk_rev | input | 1 | Reverse capture clock; its rising edge stores b_in |
| oe_n | input | 1 | Active-low output enable; high isolates both buses |
| dir | input | 1 | 1 drives the B bus, 0 drives the A bus |
| sel_fwd | input | 1 | B-side source: 0 live a_in, 1 forward register |
| sel_rev | input | 1 | A-side source: 0 live b_in, 1 reverse register |
| a_out | output | 8 | Data presented to the A bus |
| a_oe | output | 8 | A-bus drive enable, all ones when driven |
| b_out | output | 8 | Data presented to the B bus |
| b_oe | output | 8 | B-bus drive enable, all ones when driven |

## Verification
The enable vectors and the live data paths are combinational, so their results are due in the same cycle as the input change. The bench drives inputs on the falling edge and samples 2 ns later. A stored result is due one system clock after the edge at which the capture clock first reads high. The bench raises the capture clock on a falling edge and reads the stored path on the next falling edge. Before that, it changes the bus input, so that a live value cannot be mistaken for a stored one. Where it checks that data was not captured, it samples several cycles after the hold or falling stimulus.

// File: rtl/xcvr_pkg.sv
// Shared definitions for the dual-register bus transceiver.
// Assumes channel 0 is the A-to-B path and channel 1 the B-to-A path.
package xcvr_pkg;
    localparam int unsigned CH_FWD = 0;
    localparam int unsigned CH_REV = 1;
    localparam int unsigned NUM_CH = 2;

    typedef enum logic [1:0] {
        DRV_NONE = 2'b00,
        DRV_A    = 2'b01,
        DRV_B    = 2'b10
    } drive_e;
endpackage

// File: rtl/xcvr_edge_detect.sv
// Detects a rising edge of a slow capture clock sampled by the system clock.
// Assumes the sampled signal is already synchronous to clk. The previous
// sample resets high, so a clock held high through reset does not capture.
module xcvr_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    output logic rise_o
);
    logic prev_q;

    // Remember the last sampled level of the capture clock.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sample_i;
    end

    // A rise is a high sample whose previous sample was low.
    assign rise_o = sample_i & ~prev_q;
endmodule

// File: rtl/xcvr_capture_reg.sv
// Storage register for one transfer direction; loads d_i when cap_i is set.
// Assumes cap_i is a single-cycle pulse from the edge detector.
module xcvr_capture_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    // Clear on reset, load on a capture pulse, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_o <= '0;
        else if (cap_i) q_o <= d_i;
    end

    // R2 and R3: a capture pulse loads the bus value seen in that cycle.
    p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> (q_o == $past(d_i)));

    // R9 and R10: with no capture pulse the stored value does not move.
    p_hold_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(q_o));
endmodule

// File: rtl/xcvr_drive_ctrl.sv
// Decodes the output enable and direction into which bus is driven.
// Assumes oe_n is active low and dir=1 selects the B bus.
module xcvr_drive_ctrl
    import xcvr_pkg::*;
(
    input  logic   oe_n_i,
    input  logic   dir_i,
    output drive_e mode_o
);
    // Isolation wins; otherwise direction picks the receiving bus.
    always_comb begin
        if (oe_n_i)     mode_o = DRV_NONE;
        else if (dir_i) mode_o = DRV_B;
        else            mode_o = DRV_A;
    end
endmodule

// File: rtl/xcvr_path_mux.sv
// Chooses live or stored data for one driven side.
// Assumes sel_i=1 means stored data.
module xcvr_path_mux #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             sel_i,
    input  logic [WIDTH-1:0] live_i,
    input  logic [WIDTH-1:0] stored_i,
    output logic [WIDTH-1:0] out_o
);
    // Pick the output source.
    always_comb begin
        out_o = sel_i ? stored_i : live_i;
    end
endmodule

// File: rtl/dual_reg_bus_xcvr.sv
// Top of the dual-register bus transceiver. Each direction has an edge
// detector, a capture register and a source mux, built by a generate loop.
// Assumes the capture clocks change slowly relative to clk.
module dual_reg_bus_xcvr
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             cap_clk_fwd,
    input  logic             cap_clk_rev,
    input  logic             oe_n,
    input  logic             dir,
    input  logic             sel_fwd,
    input  logic             sel_rev,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe
);
    logic [WIDTH-1:0] ch_src    [NUM_CH];
    logic             ch_clk    [NUM_CH];
    logic             ch_sel    [NUM_CH];
    logic             ch_rise   [NUM_CH];
    logic [WIDTH-1:0] ch_stored [NUM_CH];
    logic [WIDTH-1:0] ch_out    [NUM_CH];
    drive_e           mode;

    // Map the ports onto the per-direction channel arrays.
    assign ch_src[CH_FWD] = a_in;
    assign ch_src[CH_REV] = b_in;
    assign ch_clk[CH_FWD] = cap_clk_fwd;
    assign ch_clk[CH_REV] = cap_clk_rev;
    assign ch_sel[CH_FWD] = sel_fwd;
    assign ch_sel[CH_REV] = sel_rev;

    for (genvar d = 0; d < NUM_CH; d++) begin : g_ch
        xcvr_edge_detect u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (ch_clk[d]),
            .rise_o   (ch_rise[d])
        );

        xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .cap_i (ch_rise[d]),
            .d_i   (ch_src[d]),
            .q_o   (ch_stored[d])
        );

        xcvr_path_mux #(.WIDTH(WIDTH)) u_mux (
            .sel_i    (ch_sel[d]),
            .live_i   (ch_src[d]),
            .stored_i (ch_stored[d]),
            .out_o    (ch_out[d])
        );

        // R9: a capture pulse never lasts two cycles.
        p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ch_rise[d] |=> !ch_rise[d]);
    end

    xcvr_drive_ctrl u_ctrl (
        .oe_n_i (oe_n),
        .dir_i  (dir),
        .mode_o (mode)
    );

    // The forward channel feeds the B side and the reverse channel the A side.
    assign b_out = ch_out[CH_FWD];
    assign a_out = ch_out[CH_REV];
    assign a_oe  = {WIDTH{mode == DRV_A}};
    assign b_oe  = {WIDTH{mode == DRV_B}};

    // R8: the two buses are never driven together.
    p_oe_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !((|a_oe) && (|b_oe)));

    // R5: an inactive output enable releases both buses.
    p_isolate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> (a_oe == '0 && b_oe == '0));

    // R6: an active enable with direction 1 drives the whole B bus.
    p_dir_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && dir) |-> (b_oe == '1));

    // R6: an active enable with direction 0 drives the whole A bus.
    p_dir_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !dir) |-> (a_oe == '1));
endmodule

// File: tb/dual_reg_bus_xcvr_tb.sv
module dual_reg_bus_xcvr_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, b_in;
    logic         cap_clk_fwd, cap_clk_rev;
    logic         oe_n, dir, sel_fwd, sel_rev;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    dual_reg_bus_xcvr #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
        .cap_clk_fwd(cap_clk_fwd), .cap_clk_rev(cap_clk_rev),
        .oe_n(oe_n), .dir(dir), .sel_fwd(sel_fwd), .sel_rev(sel_rev),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    // {oe_n, dir, sel_fwd, sel_rev, a_in, b_in, a_drv, b_drv, a_out, b_out}
    // Both registers hold zero while this table runs.
    localparam logic [37:0] VEC [6] = '{
        {4'b1100, 8'hA5, 8'h3C, 2'b00, 8'h3C, 8'hA5},
        {4'b0100, 8'h5A, 8'hC3, 2'b01, 8'hC3, 8'h5A},
        {4'b0000, 8'h12, 8'h34, 2'b10, 8'h34, 8'h12},
        {4'b0110, 8'hFF, 8'h0F, 2'b01, 8'h0F, 8'h00},
        {4'b0001, 8'h77, 8'h88, 2'b10, 8'h00, 8'h77},
        {4'b1011, 8'h01, 8'h80, 2'b00, 8'h00, 8'h00}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Raise the chosen capture clocks for one cycle, then lower them.
    task automatic pulse(input logic fwd, input logic rev);
        @(negedge clk);
        cap_clk_fwd = fwd;
        cap_clk_rev = rev;
        @(negedge clk);
        cap_clk_fwd = 1'b0;
        cap_clk_rev = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; a_in = '0; b_in = '0;
        cap_clk_fwd = 1'b0; cap_clk_rev = 1'b0;
        oe_n = 1'b1; dir = 1'b0; sel_fwd = 1'b0; sel_rev = 1'b0;
        do_reset();

        // Vector table: R1 R4 R5 R6 R8
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            {oe_n, dir, sel_fwd, sel_rev, a_in, b_in} = VEC[i][37:18];
            #2;
            check($sformatf("R5/R6 a_oe vec %0d", i), a_oe, {W{VEC[i][17]}});
            check($sformatf("R5/R6 b_oe vec %0d", i), b_oe, {W{VEC[i][16]}});
            check($sformatf("R1/R4 a_out vec %0d", i), a_out, VEC[i][15:8]);
            check($sformatf("R1/R4 b_out vec %0d", i), b_out, VEC[i][7:0]);
            check($sformatf("R8 exclusive vec %0d", i), a_oe & b_oe, 0);
        end

        // R2: forward capture; not visible before the sampling edge.
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b1; sel_fwd = 1'b1; sel_rev = 1'b1; a_in = 8'hC7;
        cap_clk_fwd = 1'b1;
        #2 check("R2 before edge", b_out, 8'h00);
        @(negedge clk);
        a_in = 8'h11;
        #2 check("R2 stored fwd", b_out, 8'hC7);
        // R10: reverse register untouched by forward capture.
        check("R10 rev kept", a_out, 8'h00);

        // R9: clock held high, then falling, captures nothing more.
        a_in = 8'h22;
        repeat (3) @(negedge clk);
        #2 check("R9 held high", b_out, 8'hC7);
        cap_clk_fwd = 1'b0;
        a_in = 8'h33;
        repeat (3) @(negedge clk);
        #2 check("R9 falling", b_out, 8'hC7);

        // R3: reverse capture; R10 forward unaffected.
        b_in = 8'h9E;
        pulse(1'b0, 1'b1);
        b_in = 8'h44;
        dir = 1'b0;
        #2 check("R3 stored rev", a_out, 8'h9E);
        check("R10 fwd kept", b_out, 8'hC7);

        // R7: captures during isolation.
        oe_n = 1'b1;
        a_in = 8'h4B; b_in = 8'hD2;
        pulse(1'b1, 1'b1);
        a_in = 8'h00; b_in = 8'h00;
        #2 check("R7 isolated a_oe", a_oe, 8'h00);
        check("R7 isolated b_oe", b_oe, 8'h00);
        @(negedge clk);
        oe_n = 1'b0; dir = 1'b1;
        #2 check("R7 fwd stored", b_out, 8'h4B);
        check("R7 b_oe", b_oe, 8'hFF);
        @(negedge clk);
        dir = 1'b0;
        #2 check("R7 rev stored", a_out, 8'hD2);
        check("R7 a_oe", a_oe, 8'hFF);

        // R1: mid-run reset clears both registers.
        do_reset();
        #2 check("R1 fwd cleared", b_out, 8'h00);
        check("R1 rev cleared", a_out, 8'h00);

        summary();
        $finish;
    end
endmodule